// File: doc/BRIEF.md
# Per-Core Miss Quota and Injection Pacer

This block sits between one core and the shared cache path and makes the core obey a throttling level that is chosen elsewhere. A three-bit level index selects one of eight throttling steps. Each step sets two limits at once. The first is a quota on how many misses the core may have in flight. The second is the minimum number of cycles between two requests sent toward the last-level cache.

The core offers requests through a valid/ready handshake. A request is taken on a clock edge where valid and ready are both high. Each request taken adds one to the in-flight count. A single-cycle free pulse, raised when a miss completes, takes one away. The in-flight count is visible on an output. A free pulse that arrives when nothing is in flight raises an error flag.

Top module: `mshr_throttle_gate`

## Requirements
- R1: While reset is asserted and right after it is released, the in-flight count is 0, ready is high and the error flag is low.
- R2: Level index 0 to 7 stands for a share of 100, 50, 25, 10, 5, 4, 3 and 2 percent of a 128-entry pool. The quota is the share of 128 rounded down, giving 128, 64, 32, 12, 6, 5, 3 and 2. Once the in-flight count reaches the quota, ready stays low.
- R3: Level index 0 to 7 sets an issue period of 1, 2, 4, 10, 20, 25, 30 and 50 cycles. While valid is held high, two taken requests are exactly that many cycles apart.
- R4: Ready is high only when the in-flight count is below the quota and the issue timer has expired. Each taken request raises the count by one on the following cycle.
- R5: Taking a request restarts the issue timer, so for any period above 1 ready is low in the next cycle. Once the timer has expired it stays expired for as long as no request is taken.
- R6: A level change acts on ready in the same cycle. If the count is already at or above the new quota, ready stays low and the count is not reduced. Only free pulses bring the count down.
- R7: A taken request and a valid free pulse in the same cycle leave the count unchanged.
- R8: A free pulse while the count is 0 raises the error flag for exactly the next cycle, and the count stays 0.
- R9: A free pulse while the count is above 0 lowers the count by one on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| level_i | input | 3 | Throttling level index, 0 = least throttled |
| req_valid_i | input | 1 | Core offers a miss request |
| req_ready_o | output | 1 | Gate admits a request this cycle |
| free_i | input | 1 | One in-flight miss has completed |
| outstanding_o | output | 8 | Current in-flight count |
| free_err_o | output | 1 | Free arrived with nothing in flight (one cycle late) |

## Verification
Ready is combinational. It follows the level, the count and the timer in the same cycle, so the bench reads it a moment after each change of input, at the falling edge before the next rising edge. The count and the error flag are registers. Each is checked at the falling edge after the rising edge that took the request, the free pulse or the bad free. The bench drives inputs and samples outputs at falling edges. It therefore measures issue gaps in whole cycles, counted from one ready sample to the next while valid is held high.

// File: rtl/mshr_thr_pkg.sv
package mshr_thr_pkg;

  localparam int LVL_N = 8;

  // share of the pool, in percent, for each level index
  function automatic int lvl_share(input int idx);
    case (idx)
      0: lvl_share = 100;
      1: lvl_share = 50;
      2: lvl_share = 25;
      3: lvl_share = 10;
      4: lvl_share = 5;
      5: lvl_share = 4;
      6: lvl_share = 3;
      default: lvl_share = 2;
    endcase
  endfunction

  // minimum cycles between two injected requests
  function automatic int lvl_gap(input int idx);
    case (idx)
      0: lvl_gap = 1;
      1: lvl_gap = 2;
      2: lvl_gap = 4;
      3: lvl_gap = 10;
      4: lvl_gap = 20;
      5: lvl_gap = 25;
      6: lvl_gap = 30;
      default: lvl_gap = 50;
    endcase
  endfunction

endpackage

// File: rtl/mshr_thr_lut.sv
module mshr_thr_lut
  import mshr_thr_pkg::*;
#(
  parameter int POOL  = 128,
  parameter int CNT_W = $clog2(POOL + 1),
  parameter int PER_W = 6,
  parameter int LVL_W = $clog2(LVL_N)
) (
  input  logic [LVL_W-1:0] level_i,
  output logic [CNT_W-1:0] quota_o,
  output logic [PER_W-1:0] period_o
);

  logic [CNT_W-1:0] q_tab [LVL_N];
  logic [PER_W-1:0] p_tab [LVL_N];

  for (genvar g = 0; g < LVL_N; g++) begin : g_tab
    assign q_tab[g] = CNT_W'((POOL * lvl_share(g)) / 100);
    assign p_tab[g] = PER_W'(lvl_gap(g));
  end

  assign quota_o  = q_tab[level_i];
  assign period_o = p_tab[level_i];

endmodule

// File: rtl/mshr_issue_pacer.sv
module mshr_issue_pacer #(
  parameter int PER_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic [PER_W-1:0] period_i,
  output logic             expired_o
);

  logic [PER_W-1:0] wait_q, wait_d;
  logic             wait_en;

  assign wait_en = accept_i || (wait_q != '0);

  always_comb begin
    wait_d = wait_q;
    if (accept_i)            wait_d = period_i - PER_W'(1);
    else if (wait_q != '0)   wait_d = wait_q - PER_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wait_q <= '0;
    else if (wait_en) wait_q <= wait_d;
  end

  assign expired_o = (wait_q == '0);

  // R5: a request taken with a period above one blocks the next cycle
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && period_i > PER_W'(1)) |=> !expired_o);

  // R5: expiry holds while nothing is taken
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_o && !accept_i) |=> expired_o);

endmodule

// File: rtl/mshr_credit.sv
module mshr_credit #(
  parameter int POOL  = 128,
  parameter int CNT_W = $clog2(POOL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_i,
  input  logic             free_i,
  output logic [CNT_W-1:0] count_o,
  output logic             err_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;
  logic             free_ok, cnt_en;

  assign free_ok = free_i && (cnt_q != '0);
  assign err_d   = free_i && (cnt_q == '0);
  assign cnt_en  = alloc_i ^ free_ok;

  always_comb begin
    cnt_d = cnt_q;
    if (alloc_i && !free_ok)      cnt_d = cnt_q + CNT_W'(1);
    else if (!alloc_i && free_ok) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign count_o = cnt_q;
  assign err_o   = err_q;

  // R2
  pool_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(POOL));

  // R7
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && free_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q)));

  // R8
  bad_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_i && !alloc_i && cnt_q == '0) |=> (err_o && cnt_q == '0));

  // R9
  free_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_i && !alloc_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/mshr_throttle_gate.sv
module mshr_throttle_gate
  import mshr_thr_pkg::*;
#(
  parameter int POOL  = 128,
  parameter int PER_W = 6,
  parameter int CNT_W = $clog2(POOL + 1),
  parameter int LVL_W = $clog2(LVL_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             free_i,
  output logic [CNT_W-1:0] outstanding_o,
  output logic             free_err_o
);

  logic [CNT_W-1:0] quota;
  logic [PER_W-1:0] period;
  logic             expired;
  logic             accept;
  logic [CNT_W-1:0] count;

  mshr_thr_lut #(.POOL(POOL), .CNT_W(CNT_W), .PER_W(PER_W), .LVL_W(LVL_W)) u_lut (
    .level_i  (level_i),
    .quota_o  (quota),
    .period_o (period)
  );

  mshr_issue_pacer #(.PER_W(PER_W)) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (accept),
    .period_i  (period),
    .expired_o (expired)
  );

  mshr_credit #(.POOL(POOL), .CNT_W(CNT_W)) u_credit (
    .clk     (clk),
    .rst_n   (rst_n),
    .alloc_i (accept),
    .free_i  (free_i),
    .count_o (count),
    .err_o   (free_err_o)
  );

  assign req_ready_o   = (count < quota) && expired;
  assign accept        = req_valid_i && req_ready_o;
  assign outstanding_o = count;

  // R4
  admit_quota_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (count < quota && expired));

  // R4
  admit_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !free_i) |=> (count == $past(count) + CNT_W'(1)));

  // R6
  over_quota_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= quota) |-> !req_ready_o);

endmodule

// File: tb/tb_mshr_throttle_gate.sv
`timescale 1ns/1ps
module tb_mshr_throttle_gate;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] level;
  logic       valid, free;
  logic       ready;
  logic [7:0] outst;
  logic       ferr;

  int checks = 0;
  int errors = 0;

  // columns: level index, expected quota, expected issue period
  localparam int VEC [8][3] = '{
    '{0, 128, 1}, '{1, 64, 2}, '{2, 32, 4}, '{3, 12, 10},
    '{4, 6, 20}, '{5, 5, 25}, '{6, 3, 30}, '{7, 2, 50}
  };

  always #2 clk = ~clk;

  mshr_throttle_gate dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .level_i       (level),
    .req_valid_i   (valid),
    .req_ready_o   (ready),
    .free_i        (free),
    .outstanding_o (outst),
    .free_err_o    (ferr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic f);
    valid = v;
    free  = f;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    free  = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    valid = 1'b0;
    free  = 1'b0;
    level = 3'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
  endtask

  initial begin
    #(4.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    valid = 1'b0;
    free  = 1'b0;
    level = 3'd0;
    @(negedge clk);
    check("R1 count in reset", int'(outst), 0);
    check("R1 err in reset", int'(ferr), 0);
    do_reset();
    check("R1 count after reset", int'(outst), 0);
    check("R1 ready after reset", int'(ready), 1);
    check("R1 err after reset", int'(ferr), 0);

    // table walk: quota (R2) and issue spacing (R3)
    for (int i = 0; i < 8; i++) begin
      int last, n, gap_bad;
      do_reset();
      level = 3'(VEC[i][0]);
      last = -1;
      n = 0;
      gap_bad = 0;
      for (int c = 0; c < VEC[i][1] * VEC[i][2] + 40; c++) begin
        if (ready) begin
          if (last >= 0 && (c - last) != VEC[i][2]) begin
            gap_bad++;
            check("R3 issue gap", c - last, VEC[i][2]);
          end
          last = c;
          n++;
        end
        valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
      end
      valid = 1'b0;
      check("R3 all gaps match", gap_bad, 0);
      check("R2 accepted count", n, VEC[i][1]);
      check("R2 outstanding at quota", int'(outst), VEC[i][1]);
      check("R2 ready low at quota", int'(ready), 0);
    end

    // R7 and R9
    do_reset();
    repeat (5) step(1'b1, 1'b0);
    check("R4 count after five", int'(outst), 5);
    step(1'b1, 1'b1);
    check("R7 pair leaves count", int'(outst), 5);
    step(1'b0, 1'b1);
    check("R9 free decrements", int'(outst), 4);

    // R6: quota drop below count
    repeat (6) step(1'b1, 1'b0);
    check("R6 count before drop", int'(outst), 10);
    level = 3'd6;
    #0.5;
    check("R6 ready drops at once", int'(ready), 0);
    repeat (3) step(1'b1, 1'b0);
    check("R6 no cancellation", int'(outst), 10);
    repeat (7) step(1'b1, 1'b1);
    check("R6 freed to three", int'(outst), 3);
    check("R6 still blocked at quota", int'(ready), 0);
    step(1'b0, 1'b1);
    check("R6 below quota count", int'(outst), 2);
    check("R6 ready below quota", int'(ready), 1);

    // R8
    do_reset();
    step(1'b0, 1'b1);
    check("R8 err raised", int'(ferr), 1);
    check("R8 count stays zero", int'(outst), 0);
    step(1'b0, 1'b0);
    check("R8 err one cycle", int'(ferr), 0);

    // R5
    do_reset();
    level = 3'd7;
    #0.5;
    step(1'b1, 1'b0);
    check("R5 restart blocks", int'(ready), 0);
    check("R4 count one", int'(outst), 1);
    repeat (100) step(1'b0, 1'b0);
    check("R5 expiry sticky", int'(ready), 1);
    step(1'b1, 1'b0);
    check("R5 second accept", int'(outst), 2);
    repeat (60) step(1'b0, 1'b0);
    check("R2 level 7 quota holds", int'(ready), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule